// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block turns a virtual address into a real address by reading translation tables from memory. A control word chosen by the address-space mode gives the origin and depth of the top table. The walk can begin at any of four region or segment depths. It then descends one table per memory read until it reaches a page-table entry, which supplies the page frame and a read-only flag. A single 64-bit read port carries every table fetch. Each fetch completes when the memory answers with a read-valid pulse.

The caller pulses a start request with the address, the access kind, the mode and a translation-enable bit. Some cycles later the block raises a one-cycle done strobe. With it come either a real address and permission flags, or a fault code and an exception word that names the faulting page and space. Real addresses that land in the low 8 KiB window are moved by a prefix base before they are returned.

Top module: `xlat_walker`

## Requirements
- R1: `mode_i` selects the control word: 1 (and the reserved value 0) selects `scw_pri_i`, 2 selects `scw_sec_i`, 3 selects `scw_home_i`. The space code placed in an exception word is 1 for primary, 2 for secondary and 3 for home.
- R2: When `dat_en_i` is 0, the result is the virtual address with its low 12 bits cleared. Permissions are all set, no memory read is issued, and there is no fault.
- R3: Before any read, the top type in control-word bits [3:2] limits the address. Type 2 allows no bit of 0xFFE0000000000000, type 1 no bit of 0xFFFFFC0000000000, and type 0 no bit of 0xFFFFFFFF80000000. A violation gives fault code 1 (specification).
- R4: Control-word bit 5 set gives fault code 2 (segment). Bit 6 set (real space) returns the page-aligned virtual address without any memory read.
- R5: Tables are read from the top type down to type 0, then one page-table read follows. For table type t the read address is origin + ((va >> (17+11t)) & 0x3FF8). The page-table read address is origin + ((va >> 9) & 0x7F8). Origins are bits [63:12] of the parent word, except after a type-0 entry, where they are bits [63:11]. Only one read is outstanding at a time, and every read address is 8-byte aligned.
- R6: A table entry with bit 5 set gives fault code 2. A table entry whose bits [3:2] differ from the type of the table it was read from gives fault code 1.
- R7: A page-table entry with bit 10 set gives fault code 3 (page). Bit 9 set (read-only) clears the write permission. The frame is bits [63:12].
- R8: A write (`acc_i` = 1) to a read-only page gives fault code 4 (protection), with exception word = page address | space code | 4. Faults 1 to 3 give page address | space code.
- R9: In mode 2, a fetch (`acc_i` = 2) walks the primary space and keeps only execute permission. Reads and writes walk the secondary space and lose execute permission.
- R10: A resulting real address below 0x2000 has `prefix_i` added to it.
- R11: A start request that arrives while a walk is in progress is ignored.
- R12: `done_o` is a one-cycle pulse. On a fault, `raddr_o` and `perm_o` are 0. On success, `fault_o` and `xword_o` are 0. `perm_o` bits are {execute, write, read}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a translation (sampled when idle) |
| va_i | input | 64 | Virtual address |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| mode_i | input | 2 | Address-space mode |
| dat_en_i | input | 1 | Translation enable |
| scw_pri_i | input | 64 | Primary space control word |
| scw_sec_i | input | 64 | Secondary space control word |
| scw_home_i | input | 64 | Home space control word |
| prefix_i | input | 64 | Prefix base for low real addresses |
| mem_req_o | output | 1 | Table read request (one cycle) |
| mem_addr_o | output | 64 | Table read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |
| done_o | output | 1 | Result strobe |
| raddr_o | output | 64 | Real address |
| perm_o | output | 3 | Permissions {x, w, r} |
| fault_o | output | 3 | Fault code, 0 when none |
| xword_o | output | 64 | Translation-exception word |

## Verification
The hardest case to reach is a start request that lands while a five-read walk from a first-level region top is still waiting on memory. It needs a complete chain of valid, correctly typed entries, plus a second request timed into the middle of the walk. The bench holds a fixed table image that contains such a chain. It fires a conflicting start a few cycles after launching a walk and checks that exactly one result, belonging to the first request, comes back. It also stretches memory latency to show that each level waits for its read-valid pulse.

// File: rtl/xw_pkg.sv
`timescale 1ns/1ps
package xw_pkg;
  localparam int unsigned XW_AW         = 64;
  localparam int unsigned XW_NLVL       = 4;
  localparam int unsigned XW_LVL_W      = $clog2(XW_NLVL);
  localparam int unsigned XW_IDX_BASE   = 17;
  localparam int unsigned XW_IDX_STEP   = 11;
  localparam int unsigned XW_PT_SHIFT   = 9;
  localparam logic [XW_AW-1:0] XW_TBL_IDX_MASK = 64'h3FF8;
  localparam logic [XW_AW-1:0] XW_PT_IDX_MASK  = 64'h7F8;
  localparam logic [XW_AW-1:0] XW_PAGE_MASK    = ~64'hFFF;
  localparam logic [XW_AW-1:0] XW_PT_ORG_MASK  = ~64'h7FF;
  localparam logic [XW_AW-1:0] XW_PROT_TAG     = 64'h4;
  localparam int unsigned XW_INV_BIT     = 5;
  localparam int unsigned XW_REAL_BIT    = 6;
  localparam int unsigned XW_TYPE_LSB    = 2;
  localparam int unsigned XW_PTE_RO_BIT  = 9;
  localparam int unsigned XW_PTE_INV_BIT = 10;

  typedef enum logic [2:0] {
    XF_NONE = 3'd0, XF_SPEC = 3'd1, XF_SEG = 3'd2, XF_PAGE = 3'd3, XF_PROT = 3'd4
  } xw_fault_e;

  typedef enum logic [1:0] {XA_READ = 2'd0, XA_WRITE = 2'd1, XA_FETCH = 2'd2} xw_acc_e;

  function automatic logic [XW_AW-1:0] xw_fit_mask(input logic [XW_LVL_W-1:0] top);
    case (top)
      2'd2:    xw_fit_mask = 64'hFFE0_0000_0000_0000;
      2'd1:    xw_fit_mask = 64'hFFFF_FC00_0000_0000;
      2'd0:    xw_fit_mask = 64'hFFFF_FFFF_8000_0000;
      default: xw_fit_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/xw_space_sel.sv
`timescale 1ns/1ps
module xw_space_sel
  import xw_pkg::*;
(
  input  logic [1:0]       mode_i,
  input  logic [1:0]       acc_i,
  input  logic [XW_AW-1:0] scw_pri_i,
  input  logic [XW_AW-1:0] scw_sec_i,
  input  logic [XW_AW-1:0] scw_home_i,
  output logic [XW_AW-1:0] scw_o,
  output logic [1:0]       mcode_o,
  output logic [2:0]       pmask_o
);
  always_comb begin
    scw_o   = scw_pri_i;
    mcode_o = 2'd1;
    pmask_o = 3'b111;
    case (mode_i)
      2'd2: begin
        if (acc_i == XA_FETCH) begin
          pmask_o = 3'b100;          // fetch: primary space, execute only
        end else begin
          scw_o   = scw_sec_i;
          mcode_o = 2'd2;
          pmask_o = 3'b011;
        end
      end
      2'd3: begin
        scw_o   = scw_home_i;
        mcode_o = 2'd3;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xw_addr_gen.sv
`timescale 1ns/1ps
module xw_addr_gen
  import xw_pkg::*;
#(
  parameter int unsigned NLVL  = XW_NLVL,
  parameter int unsigned LVL_W = XW_LVL_W
) (
  input  logic [XW_AW-1:0] va_i,
  input  logic [XW_AW-1:0] org_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             pte_i,
  output logic [XW_AW-1:0] addr_o
);
  logic [XW_AW-1:0] cand [NLVL];

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    localparam int unsigned SH = XW_IDX_BASE + XW_IDX_STEP * g;
    assign cand[g] = org_i + ((va_i >> SH) & XW_TBL_IDX_MASK);
  end

  assign addr_o = pte_i ? org_i + ((va_i >> XW_PT_SHIFT) & XW_PT_IDX_MASK) : cand[lvl_i];
endmodule

// File: rtl/xw_entry_chk.sv
`timescale 1ns/1ps
module xw_entry_chk
  import xw_pkg::*;
(
  input  logic [XW_AW-1:0]    ent_i,
  input  logic [XW_LVL_W-1:0] lvl_i,
  input  logic                pte_i,
  output xw_fault_e           fault_o,
  output logic [XW_AW-1:0]    org_o,
  output logic [XW_AW-1:0]    frame_o,
  output logic                ro_o
);
  always_comb begin
    fault_o = XF_NONE;
    if (pte_i) begin
      if (ent_i[XW_PTE_INV_BIT]) fault_o = XF_PAGE;
    end else if (ent_i[XW_INV_BIT]) begin
      fault_o = XF_SEG;
    end else if (ent_i[XW_TYPE_LSB +: XW_LVL_W] != lvl_i) begin
      fault_o = XF_SPEC;
    end
  end

  // page tables under a type-0 entry sit on 2 KiB boundaries
  assign org_o   = (lvl_i == '0) ? (ent_i & XW_PT_ORG_MASK) : (ent_i & XW_PAGE_MASK);
  assign frame_o = ent_i & XW_PAGE_MASK;
  assign ro_o    = ent_i[XW_PTE_RO_BIT];
endmodule

// File: rtl/xlat_walker.sv
`timescale 1ns/1ps
module xlat_walker
  import xw_pkg::*;
#(
  parameter logic [63:0] PREFIX_LIMIT = 64'h2000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [63:0] va_i,
  input  logic [1:0]  acc_i,
  input  logic [1:0]  mode_i,
  input  logic        dat_en_i,
  input  logic [63:0] scw_pri_i,
  input  logic [63:0] scw_sec_i,
  input  logic [63:0] scw_home_i,
  input  logic [63:0] prefix_i,
  output logic        mem_req_o,
  output logic [63:0] mem_addr_o,
  input  logic        mem_rvalid_i,
  input  logic [63:0] mem_rdata_i,
  output logic        done_o,
  output logic [63:0] raddr_o,
  output logic [2:0]  perm_o,
  output logic [2:0]  fault_o,
  output logic [63:0] xword_o
);
  typedef enum logic [1:0] {S_IDLE, S_TOP, S_REQ, S_WAIT} st_e;

  st_e                 st_q, st_d;
  logic [XW_AW-1:0]    va_q, va_d, scw_q, scw_d, org_q, org_d;
  logic [1:0]          acc_q, acc_d, mcode_q, mcode_d;
  logic [2:0]          pmask_q, pmask_d;
  logic                dat_q, dat_d, pte_q, pte_d;
  logic [XW_LVL_W-1:0] lvl_q, lvl_d, top_type;

  logic [XW_AW-1:0]    sel_scw;
  logic [1:0]          sel_mcode;
  logic [2:0]          sel_pmask;
  xw_fault_e           chk_fault;
  logic [XW_AW-1:0]    chk_org, chk_frame;
  logic                chk_ro;

  logic                fin;
  xw_fault_e           fin_flt;
  logic [XW_AW-1:0]    fin_ra;
  logic [2:0]          fin_perm;

  logic                done_q;
  logic [XW_AW-1:0]    raddr_q, xword_q;
  logic [2:0]          perm_q, fault_q;

  xw_space_sel i_sel (
    .mode_i(mode_i), .acc_i(acc_i),
    .scw_pri_i(scw_pri_i), .scw_sec_i(scw_sec_i), .scw_home_i(scw_home_i),
    .scw_o(sel_scw), .mcode_o(sel_mcode), .pmask_o(sel_pmask)
  );

  xw_addr_gen i_agen (
    .va_i(va_q), .org_i(org_q), .lvl_i(lvl_q), .pte_i(pte_q), .addr_o(mem_addr_o)
  );

  xw_entry_chk i_echk (
    .ent_i(mem_rdata_i), .lvl_i(lvl_q), .pte_i(pte_q),
    .fault_o(chk_fault), .org_o(chk_org), .frame_o(chk_frame), .ro_o(chk_ro)
  );

  assign top_type  = scw_q[XW_TYPE_LSB +: XW_LVL_W];
  assign mem_req_o = (st_q == S_REQ);

  always_comb begin
    st_d = st_q;  va_d = va_q;  scw_d = scw_q;  org_d = org_q;
    acc_d = acc_q;  mcode_d = mcode_q;  pmask_d = pmask_q;
    dat_d = dat_q;  pte_d = pte_q;  lvl_d = lvl_q;
    fin = 1'b0;  fin_flt = XF_NONE;  fin_ra = '0;  fin_perm = '0;
    case (st_q)
      S_IDLE: if (start_i) begin
        va_d    = va_i & XW_PAGE_MASK;
        acc_d   = acc_i;
        dat_d   = dat_en_i;
        scw_d   = sel_scw;
        mcode_d = sel_mcode;
        pmask_d = sel_pmask;
        st_d    = S_TOP;
      end
      S_TOP: begin
        if (!dat_q) begin
          fin = 1'b1;  fin_ra = va_q;  fin_perm = 3'b111;
        end else if (|(va_q & xw_fit_mask(top_type))) begin
          fin = 1'b1;  fin_flt = XF_SPEC;
        end else if (scw_q[XW_INV_BIT]) begin
          fin = 1'b1;  fin_flt = XF_SEG;
        end else if (scw_q[XW_REAL_BIT]) begin
          fin = 1'b1;  fin_ra = va_q;  fin_perm = pmask_q;
        end else begin
          lvl_d = top_type;
          pte_d = 1'b0;
          org_d = scw_q & XW_PAGE_MASK;
          st_d  = S_REQ;
        end
      end
      S_REQ: st_d = S_WAIT;
      S_WAIT: if (mem_rvalid_i) begin
        if (chk_fault != XF_NONE) begin
          fin = 1'b1;  fin_flt = chk_fault;
        end else if (pte_q) begin
          if (acc_q == XA_WRITE && chk_ro) begin
            fin = 1'b1;  fin_flt = XF_PROT;
          end else begin
            fin = 1'b1;  fin_ra = chk_frame;  fin_perm = {1'b1, !chk_ro, 1'b1} & pmask_q;
          end
        end else begin
          org_d = chk_org;
          st_d  = S_REQ;
          if (lvl_q == '0) pte_d = 1'b1;
          else             lvl_d = lvl_q - XW_LVL_W'(1);
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (fin) st_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE;  va_q <= '0;  scw_q <= '0;  org_q <= '0;
      acc_q <= '0;  mcode_q <= '0;  pmask_q <= '0;
      dat_q <= 1'b0;  pte_q <= 1'b0;  lvl_q <= '0;
      done_q <= 1'b0;  raddr_q <= '0;  xword_q <= '0;  perm_q <= '0;  fault_q <= '0;
    end else begin
      st_q <= st_d;  va_q <= va_d;  scw_q <= scw_d;  org_q <= org_d;
      acc_q <= acc_d;  mcode_q <= mcode_d;  pmask_q <= pmask_d;
      dat_q <= dat_d;  pte_q <= pte_d;  lvl_q <= lvl_d;
      done_q <= fin;
      if (fin) begin
        fault_q <= fin_flt;
        if (fin_flt == XF_NONE) begin
          raddr_q <= (fin_ra < PREFIX_LIMIT) ? fin_ra + prefix_i : fin_ra;
          perm_q  <= fin_perm;
          xword_q <= '0;
        end else begin
          raddr_q <= '0;
          perm_q  <= '0;
          xword_q <= va_q | XW_AW'(mcode_q) | ((fin_flt == XF_PROT) ? XW_PROT_TAG : '0);
        end
      end
    end
  end

  assign done_o  = done_q;
  assign raddr_o = raddr_q;
  assign perm_o  = perm_q;
  assign fault_o = fault_q;
  assign xword_o = xword_q;
endmodule

// File: rtl/xw_checker.sv
`timescale 1ns/1ps
module xw_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        done_o,
  input logic [2:0]  fault_o,
  input logic [63:0] raddr_o,
  input logic [2:0]  perm_o,
  input logic [63:0] xword_o,
  input logic        mem_req_o,
  input logic [63:0] mem_addr_o
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R12
  AST_FAULT_CLEARS_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o != 3'd0) |-> (raddr_o == 64'd0 && perm_o == 3'd0));  // R12
  AST_OK_NO_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o == 3'd0) |-> xword_o == 64'd0);  // R12
  AST_PROT_WORD_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o == 3'd4) |-> (xword_o[2] && xword_o[1:0] != 2'd0));  // R8
  AST_OTHER_WORD_TAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o != 3'd0 && fault_o != 3'd4) |-> (!xword_o[2] && xword_o[1:0] != 2'd0));  // R8
  AST_ONE_READ_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);  // R5
  AST_READ_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o & 64'h7) == 64'd0);  // R5
  AST_NO_READ_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !done_o);  // R12
endmodule

bind xlat_walker xw_checker i_xw_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_o(done_o), .fault_o(fault_o),
  .raddr_o(raddr_o), .perm_o(perm_o), .xword_o(xword_o),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o)
);

// File: tb/test_xlat_walker.sv
`timescale 1ns/1ps
module test_xlat_walker;
  typedef struct packed {
    logic [63:0] va;  logic [1:0] acc;  logic [1:0] mode;  logic dat;
    logic [63:0] sp;  logic [63:0] ss;  logic [63:0] sh;
    logic [2:0]  ef;  logic [63:0] era; logic [2:0] ep;  logic [63:0] exw;
    logic [3:0]  nrd; logic [3:0] req;
  } vec_t;

  localparam logic [63:0] P = 64'h10000, S = 64'h41008, H = 64'h4000C;
  localparam logic [63:0] VB = 64'h0020_0000_0000_5000;
  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{64'h123ABC, 2'd0, 2'd1, 1'b1, P, S, H, 3'd0, 64'h555000, 3'd7, 64'h0, 4'd2, 4'd1},      // R1 R5
    '{64'h124000, 2'd0, 2'd1, 1'b1, P, S, H, 3'd0, 64'h666000, 3'd5, 64'h0, 4'd2, 4'd7},      // R7 ro
    '{64'h124000, 2'd1, 2'd1, 1'b1, P, S, H, 3'd4, 64'h0, 3'd0, 64'h124005, 4'd2, 4'd8},      // R8
    '{64'h125000, 2'd0, 2'd1, 1'b1, P, S, H, 3'd3, 64'h0, 3'd0, 64'h125001, 4'd2, 4'd7},      // R7 inv
    '{64'h126000, 2'd0, 2'd1, 1'b1, P, S, H, 3'd0, 64'h81000, 3'd7, 64'h0, 4'd2, 4'd10},      // R10
    '{64'h200000, 2'd0, 2'd1, 1'b1, P, S, H, 3'd2, 64'h0, 3'd0, 64'h200001, 4'd1, 4'd6},      // R6 inv
    '{64'h300000, 2'd0, 2'd1, 1'b1, P, S, H, 3'd1, 64'h0, 3'd0, 64'h300001, 4'd1, 4'd6},      // R6 type
    '{64'h80000000, 2'd0, 2'd1, 1'b1, P, S, H, 3'd1, 64'h0, 3'd0, 64'h80000001, 4'd0, 4'd3},  // R3 seg top
    '{VB, 2'd0, 2'd3, 1'b1, P, S, H, 3'd0, 64'h777000, 3'd7, 64'h0, 4'd5, 4'd5},              // R5 deep
    '{VB, 2'd1, 2'd3, 1'b1, P, S, H, 3'd0, 64'h777000, 3'd7, 64'h0, 4'd5, 4'd8},              // R8 ok write
    '{VB, 2'd0, 2'd2, 1'b1, P, S, H, 3'd1, 64'h0, 3'd0, VB | 64'h2, 4'd0, 4'd3},              // R3 region2
    '{64'h5000, 2'd0, 2'd2, 1'b1, P, S, H, 3'd0, 64'h777000, 3'd3, 64'h0, 4'd4, 4'd9},        // R9 data
    '{64'h123000, 2'd2, 2'd2, 1'b1, P, S, H, 3'd0, 64'h555000, 3'd4, 64'h0, 4'd2, 4'd9},      // R9 fetch
    '{64'h123000, 2'd0, 2'd3, 1'b1, P, S, 64'h40, 3'd0, 64'h123000, 3'd7, 64'h0, 4'd0, 4'd4}, // R4 real
    '{64'h123000, 2'd0, 2'd1, 1'b1, 64'h10020, S, H, 3'd2, 64'h0, 3'd0, 64'h123001, 4'd0, 4'd4}, // R4 inv
    '{64'h1ABC, 2'd0, 2'd1, 1'b0, P, S, H, 3'd0, 64'h81000, 3'd7, 64'h0, 4'd0, 4'd2},         // R2
    '{64'h123000, 2'd0, 2'd0, 1'b1, P, S, H, 3'd0, 64'h555000, 3'd7, 64'h0, 4'd2, 4'd1},      // R1 mode 0
    '{64'h124000, 2'd1, 2'd2, 1'b1, P, P, H, 3'd4, 64'h0, 3'd0, 64'h124006, 4'd2, 4'd8},      // R8 secondary
    '{64'h0000_0400_0000_0000, 2'd0, 2'd1, 1'b1, 64'h42004, S, H, 3'd1, 64'h0, 3'd0,
      64'h0000_0400_0000_0001, 4'd0, 4'd3},                                                    // R3 region3
    '{64'h124000, 2'd2, 2'd2, 1'b1, P, S, H, 3'd0, 64'h666000, 3'd4, 64'h0, 4'd2, 4'd9}       // R9 fetch ro
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, dat_en_i = 1'b0;
  logic [63:0] va_i = '0, scw_pri_i = '0, scw_sec_i = '0, scw_home_i = '0, prefix_i = 64'h80000;
  logic [1:0] acc_i = '0, mode_i = '0;
  logic mem_req_o, mem_rvalid_i, done_o;
  logic [63:0] mem_addr_o, mem_rdata_i, raddr_o, xword_o;
  logic [2:0] perm_o, fault_o;

  int nchk = 0, nfail = 0, nreads = 0, ndone = 0, lat = 1;
  bit ended = 1'b0;

  always #2.5 clk_i = ~clk_i;

  xlat_walker i_xlat_walker (.*);

  function automatic logic [63:0] mem_rd(input logic [63:0] a);
    case (a)
      64'h10008: mem_rd = 64'h20800;
      64'h10010: mem_rd = 64'h20;
      64'h10018: mem_rd = 64'h20C04;
      64'h20918: mem_rd = 64'h555000;
      64'h20920: mem_rd = 64'h666200;
      64'h20928: mem_rd = 64'h400;
      64'h20930: mem_rd = 64'h1000;
      64'h40008: mem_rd = 64'h4100C;
      64'h41000: mem_rd = 64'h42008;
      64'h42000: mem_rd = 64'h43004;
      64'h43000: mem_rd = 64'h44000;
      64'h44028: mem_rd = 64'h777000;
      default:   mem_rd = 64'h0;
    endcase
  endfunction

  logic        pend;
  logic [63:0] pend_addr;
  int          pend_cnt;
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend <= 1'b0; pend_addr <= '0; pend_cnt <= 0; mem_rvalid_i <= 1'b0; mem_rdata_i <= '0;
    end else begin
      mem_rvalid_i <= 1'b0;
      if (mem_req_o) begin
        pend <= 1'b1; pend_addr <= mem_addr_o; pend_cnt <= lat; nreads <= nreads + 1;
      end else if (pend) begin
        if (pend_cnt <= 1) begin
          mem_rvalid_i <= 1'b1; mem_rdata_i <= mem_rd(pend_addr); pend <= 1'b0;
        end else pend_cnt <= pend_cnt - 1;
      end
    end
  end

  always @(posedge clk_i) if (done_o) ndone <= ndone + 1;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    va_i = v.va; acc_i = v.acc; mode_i = v.mode; dat_en_i = v.dat;
    scw_pri_i = v.sp; scw_sec_i = v.ss; scw_home_i = v.sh;
  endtask

  task automatic wait_done(input string req);
    int w = 0;
    while (!done_o && w < 200) begin @(negedge clk_i); w++; end
    chk(req, "done seen", 64'(done_o), 64'd1);
  endtask

  task automatic run_vec(input vec_t v);
    string tag;
    int r0;
    tag = $sformatf("R%0d", v.req);
    @(negedge clk_i);
    drive(v);
    r0 = nreads;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done(tag);
    chk(tag, "fault", 64'(fault_o), 64'(v.ef));
    chk(tag, "raddr", raddr_o, v.era);
    chk(tag, "perm", 64'(perm_o), 64'(v.ep));
    chk(tag, "xword", xword_o, v.exw);
    chk(tag, "reads", 64'(nreads - r0), 64'(v.nrd));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // reset state, R12
    chk("R12", "reset done", 64'(done_o), 64'd0);
    chk("R12", "reset req", 64'(mem_req_o), 64'd0);
    chk("R12", "reset fault", 64'(fault_o), 64'd0);
    chk("R12", "reset raddr", raddr_o, 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R11: second start during deep walk must be ignored
    begin
      int d0, r0;
      vec_t bad;
      bad = VECS[7];
      @(negedge clk_i);
      drive(VECS[8]);
      d0 = ndone; r0 = nreads;
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      repeat (3) @(negedge clk_i);
      drive(bad);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      wait_done("R11");
      chk("R11", "fault", 64'(fault_o), 64'd0);
      chk("R11", "raddr", raddr_o, 64'h777000);
      chk("R11", "reads", 64'(nreads - r0), 64'd5);
      repeat (8) @(negedge clk_i);
      chk("R11", "done count", 64'(ndone - d0), 64'd1);
      chk("R12", "no done when idle", 64'(done_o), 64'd0);
    end

    // R5: slow memory, each level waits for read-valid
    lat = 4;
    run_vec(VECS[8]);
    run_vec(VECS[1]);
    lat = 1;

    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!ended) begin
      ended = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule